// File: doc/BRIEF.md
# Addressable Serial Delay Line

This block is a one-bit serial delay line whose length is chosen while it runs. Each enabled clock edge pushes the serial input into a chain of sixteen one-bit stages. A tap address picks the stage that drives the output, so the delay can be set anywhere from one to sixteen enabled cycles. It is used to line up a signal with a parallel datapath whose pipeline latency differs. The line can also be used where the needed latency is known only after configuration.

A parameter chains several sixteen-stage sections. The last stage of each section feeds the serial input of the next section and is also brought out as a cascade output. The upper address bits pick the section and the low four bits pick the stage inside it. A second parameter adds an output flip-flop, which adds one enabled cycle of delay and breaks the combinational path from the address. The shift stages have no reset or set. The asynchronous active-low reset clears only the optional output flip-flop. If the section count is not a power of two, a section index past the last section gives a zero output.

Top module: `addressable_delay_line`

## Requirements
- R1: On a rising clock edge with `ce` high, the serial input is captured into stage 1 and every other stage takes the value of the stage before it. With address 0 and no output register, `dout` equals the `din` value from the most recent enabled edge.
- R2: With one section and no output register, a tap address value `a` (4 bits, 0 to 15) gives `dout` equal to the `din` value captured `a`+1 enabled edges earlier. For example, address 2 gives a three-stage delay.
- R3: While `ce` is low, no stage changes. Without an output register, `dout` then stays constant while the address stays constant, whatever `din` does.
- R4: Without an output register, a change of address takes effect on `dout` in the same cycle, with no shift needed. This holds also while `ce` is low.
- R5: Cascade output bit `s` always carries stage 16 of section `s`, whatever the address. It therefore equals the `din` captured 16·(`s`+1) enabled edges earlier.
- R6: With several sections, address bits [ADDR_W-1:4] give the section index `k` and bits [3:0] give the tap `t`. The selected stage holds the `din` captured 16·`k`+`t`+1 enabled edges earlier.
- R7: With the output register enabled, `dout` loads the selected stage on each enabled edge and holds while `ce` is low. The total delay is therefore the address value plus two enabled edges.
- R8: While `rst_n` is low, the output register drives `dout` to 0.
- R9: Reset does not clear the shift stages. Data shifted in before a reset pulse still appears at the taps after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages shift on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register only |
| ce | input | 1 | Clock enable for shifting and for the output register |
| din | input | 1 | Serial data input |
| addr | input | ADDR_W | Tap address: section index in the upper bits, stage in bits [3:0] |
| dout | output | 1 | Selected stage, registered when OUT_REG is 1 |
| casc_out | output | SECTIONS | Stage 16 of each section |

## Verification
The assertions assume that `addr` and `ce` change only between clock edges. The hold properties also need the address to be stable across the cycle in which they are checked. They assume that `rst_n` is released away from a rising edge. The stimulus meets these by driving every input on the falling edge, and by keeping `ce` low around the reset pulses. The scoreboard compares an output only after enough enabled edges have passed to fill the stage it selects. It does so because the stages come up without a reset value.

// File: rtl/adl_pkg.sv
package adl_pkg;
  localparam int unsigned SEG_STAGES = 16;
  localparam int unsigned SEG_AW     = $clog2(SEG_STAGES);

  function automatic int unsigned sec_sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned line_addr_w(input int unsigned n);
    return (n > 1) ? SEG_AW + $clog2(n) : SEG_AW;
  endfunction
endpackage

// File: rtl/adl_section.sv
module adl_section #(
  parameter int unsigned STAGES = adl_pkg::SEG_STAGES,
  localparam int unsigned AW    = $clog2(STAGES)
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          ser_in,
  input  logic [AW-1:0] tap,
  output logic          tap_q,
  output logic          cascade_q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    if (ce) begin
      stage_d = {stage_q[STAGES-2:0], ser_in};
    end else begin
      stage_d = stage_q;
    end
  end

  always_ff @(posedge clk) begin
    stage_q <= stage_d;
  end

  always_comb begin
    tap_q = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (tap == AW'(i)) tap_q = stage_q[i];
    end
  end

  assign cascade_q = stage_q[STAGES-1];
endmodule

// File: rtl/adl_tap_select.sv
module adl_tap_select #(
  parameter int unsigned N     = 2,
  parameter int unsigned SEL_W = 1
) (
  input  logic [SEL_W-1:0] sec_idx,
  input  logic [N-1:0]     taps,
  output logic             sel_q
);
  always_comb begin
    sel_q = 1'b0;
    for (int s = 0; s < N; s++) begin
      if (sec_idx == SEL_W'(s)) sel_q = taps[s];
    end
  end
endmodule

// File: rtl/adl_out_stage.sv
module adl_out_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic d,
  output logic q
);
  if (REGISTERED) begin : g_reg
    logic q_q;
    logic q_d;

    always_comb begin
      if (ce) q_d = d;
      else    q_d = q_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= 1'b0;
      else        q_q <= q_d;
    end

    assign q = q_q;
  end else begin : g_comb
    assign q = d;
  end
endmodule

// File: rtl/addressable_delay_line.sv
module addressable_delay_line #(
  parameter int unsigned SECTIONS = 2,
  parameter bit          OUT_REG  = 1'b1,
  localparam int unsigned SEL_W   = adl_pkg::sec_sel_w(SECTIONS),
  localparam int unsigned ADDR_W  = adl_pkg::line_addr_w(SECTIONS),
  localparam int unsigned TAP_W   = adl_pkg::SEG_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                din,
  input  logic [ADDR_W-1:0]   addr,
  output logic                dout,
  output logic [SECTIONS-1:0] casc_out
);
  logic [SECTIONS-1:0] chain_in;
  logic [SECTIONS-1:0] sec_tap;
  logic [SEL_W-1:0]    sec_idx;
  logic [TAP_W-1:0]    tap_lo;
  logic                tap_sel;

  assign tap_lo = addr[TAP_W-1:0];

  if (SECTIONS > 1) begin : g_idx
    assign sec_idx = addr[ADDR_W-1:TAP_W];
  end else begin : g_idx1
    assign sec_idx = '0;
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    if (s == 0) begin : g_head
      assign chain_in[s] = din;
    end else begin : g_link
      assign chain_in[s] = casc_out[s-1];
    end

    adl_section #(.STAGES(adl_pkg::SEG_STAGES)) u_sec (
      .clk       (clk),
      .ce        (ce),
      .ser_in    (chain_in[s]),
      .tap       (tap_lo),
      .tap_q     (sec_tap[s]),
      .cascade_q (casc_out[s])
    );
  end

  adl_tap_select #(.N(SECTIONS), .SEL_W(SEL_W)) u_sel (
    .sec_idx (sec_idx),
    .taps    (sec_tap),
    .sel_q   (tap_sel)
  );

  adl_out_stage #(.REGISTERED(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .d     (tap_sel),
    .q     (dout)
  );
endmodule

// File: rtl/adl_checker.sv
module adl_checker #(
  parameter int unsigned SECTIONS = 2,
  parameter bit          OUT_REG  = 1'b1,
  parameter int unsigned ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce,
  input logic [ADDR_W-1:0]   addr,
  input logic                dout,
  input logic [SECTIONS-1:0] casc_out,
  input logic                tap_sel
);
  // R3: stages frozen while ce is low, so cascade outputs hold
  a_r3_casc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(casc_out));

  if (OUT_REG) begin : g_reg_chk
    // R7: registered output loads the selected stage on enabled edges
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> (dout == $past(tap_sel)));
    // R7: registered output holds while ce is low
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(dout));
    // R8: output register cleared in reset
    always @(posedge clk) begin
      if (!rst_n) begin
        a_r8_reset_zero: assert (dout == 1'b0);
      end
    end
  end else begin : g_comb_chk
    // R3: with ce low and a steady address the output is steady
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce ##1 $stable(addr)) |-> $stable(dout));
  end

  // R5 and R6: tap 15 of section s is the same stage as cascade output s
  for (genvar s = 0; s < SECTIONS; s++) begin : g_last_tap
    a_r5_last_tap: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(s * 16 + 15)) |-> (tap_sel == casc_out[s]));
  end
endmodule

bind addressable_delay_line adl_checker #(
  .SECTIONS (SECTIONS),
  .OUT_REG  (OUT_REG),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce       (ce),
  .addr     (addr),
  .dout     (dout),
  .casc_out (casc_out),
  .tap_sel  (tap_sel)
);

// File: tb/sim_addressable_delay_line.sv
`timescale 1ns/1ps
module sim_addressable_delay_line;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0;
  logic       din = 1'b0;
  logic [4:0] a0 = '0;
  logic [3:0] a1 = '0;
  logic       dout0, dout1;
  logic [1:0] casc0;
  logic [0:0] casc1;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R8";

  always #2.5 clk = ~clk;

  addressable_delay_line #(.SECTIONS(2), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .addr(a0),
    .dout(dout0), .casc_out(casc0));

  addressable_delay_line #(.SECTIONS(1), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .addr(a1),
    .dout(dout1), .casc_out(casc1));

  typedef struct packed {
    logic e0; bit v0; bit hi0; bit rst0;
    logic e1; bit v1;
    logic c0; bit vc0;
    logic c1; bit vc1;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // reference model: history of enabled inputs, index 0 newest
  bit  hist [0:63];
  int  filled = 0;
  logic exp_r = 1'b0;
  bit   vr = 1'b1;
  bit   hr = 1'b0;

  always @(posedge clk) begin
    exp_t it;
    if (!rst_n) begin
      exp_r = 1'b0; vr = 1'b1; hr = 1'b0;
    end else if (ce) begin
      exp_r = hist[a0]; vr = (filled > int'(a0)); hr = (a0 >= 5'd16);
    end
    if (ce) begin
      for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = din;
      if (filled < 64) filled++;
    end
    it.e0 = exp_r; it.v0 = vr; it.hi0 = hr; it.rst0 = !rst_n;
    it.e1 = hist[a1]; it.v1 = (filled > int'(a1));
    it.c0 = hist[15]; it.vc0 = (filled > 15);
    it.c1 = hist[31]; it.vc1 = (filled > 31);
    exp_q.push_back(it);
    tag_q.push_back(phase);
  end

  task automatic chk(input string req, input logic act, input logic expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: compares one cycle's expectations after each edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (it.v0) chk(it.rst0 ? "R8" : (it.hi0 ? "R6" : "R7"), dout0, it.e0);
        if (it.v1) chk(tg, dout1, it.e1);
        if (it.vc0) chk("R5", casc0[0], it.c0);
        if (it.vc1) chk("R5", casc0[1], it.c1);
        if (it.vc0) chk("R5", casc1[0], it.c0);
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic cyc(input logic ce_v, input logic [4:0] ad0, input logic [3:0] ad1);
    @(negedge clk);
    lfsr = step(lfsr);
    ce  = ce_v;
    din = lfsr[0];
    a0  = ad0;
    a1  = ad1;
  endtask

  initial begin
    // R8: reset state of the output register
    phase = "R8";
    repeat (3) cyc(1'b0, 5'd0, 4'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1: address 0 gives one-stage delay; also fills the line
    phase = "R1";
    repeat (40) cyc(1'b1, 5'd0, 4'd0);
    // R2 and R6: sweep every tap with steady shifting
    phase = "R2";
    for (int a = 0; a < 32; a++) begin
      repeat (5) cyc(1'b1, 5'(a), 4'(a));
    end
    // R2: address 2 is a three-stage delay
    repeat (10) cyc(1'b1, 5'd2, 4'd2);
    // R3: ce low, address steady, din wiggling
    phase = "R3";
    repeat (8) cyc(1'b0, 5'd7, 4'd9);
    // R4: ce low, address changing every cycle
    phase = "R4";
    for (int a = 0; a < 16; a++) cyc(1'b0, 5'(31 - a), 4'(15 - a));
    // R2 and R7: enable toggling with moving taps
    phase = "R2";
    for (int k = 0; k < 120; k++) begin
      cyc(lfsr[3], 5'((k * 7) % 32), 4'((k * 5) % 16));
    end
    // R9: mid-run reset pulse must not clear the stages
    phase = "R9";
    cyc(1'b0, 5'd20, 4'd12);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) cyc(1'b0, 5'd20, 4'd12);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 16; a++) cyc(1'b0, 5'd20, 4'(a));
    repeat (30) cyc(1'b1, 5'd25, 4'd14);
    repeat (3) cyc(1'b0, 5'd0, 4'd0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule